// File: doc/BRIEF.md
# Microcoded Register-File Datapath

This block is the execution half of a horizontally microcoded machine. Every clock cycle the controller presents one wide control word on the input ports. Two read ports of a 32 x 32-bit register file drive the X and Y buses. A sign-extended 16-bit constant can stand in for Y. A single enabled producer drives the Z bus. The producers are an adder/subtractor, a bitwise truth-table logic unit, a signed-count barrel shifter, and a load from a 256-word data memory. The Z value may be written back to any register at the end of the cycle.

Sequencing, branching and control-store fetch sit outside the block. The environment supplies fully decoded fields and must enable no more than one Z producer per cycle. The X, Y and Z buses are brought out, so the controller and the bench can watch operands and results in the same cycle that produces them.

Top module: `dp_micro_core`

## Requirements
- R1: While reset is low and after it is released, every register reads zero on `x_bus` and `y_bus` until it is written.
- R2: `x_bus` and `y_bus` show the registers named by `sel_x` and `sel_y`. With `reg_we` high, the value on `z_bus` is stored into register `sel_z` at the rising clock edge. A read in the same cycle returns the value from before that write. Register 0 is an ordinary writable register.
- R3: With `imm_en` high, `y_bus` carries `imm_val` sign-extended from bit 15 to 32 bits in place of the register file output.
- R4: With `arith_en` high, Z is X+Y when `sub_mode` is 0 and X−Y when it is 1, both modulo 2^32.
- R5: With `logic_en` high, result bit i is `logic_fn[2*Y[i] + X[i]]`. Bit 0 covers X=0,Y=0, bit 1 covers X=1,Y=0, bit 2 covers X=0,Y=1 and bit 3 covers X=1,Y=1.
- R6: With `shift_en` high and a positive two's-complement `shift_cnt`, X moves right by the count. `shift_kind` 0 fills with zeros, 1 fills with copies of bit 31, 2 rotates right, and 3 acts as 0.
- R7: A negative `shift_cnt` moves X left by its magnitude. Kinds 0, 1 and 3 fill with zeros and kind 2 rotates left. A count of −32 acts as a shift of 31, and a count of 0 passes X unchanged.
- R8: With `store_en` and `mem_sel` high and `mem_rd` low, Y is written at the rising edge to the memory word indexed by X[7:0]. X[31:8] is ignored.
- R9: With `load_en`, `mem_sel` and `mem_rd` high, the word indexed by X[7:0] appears on Z in the same cycle. With `mem_sel` low, the load contributes zero.
- R10: At most one of `arith_en`, `logic_en`, `shift_en` and `load_en` is set in a cycle. With none set, Z is zero and a register write stores zero.
- R11: A store request with `mem_rd` high, or with `mem_sel` low, leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| sel_x | input | 5 | Register driving the X bus |
| sel_y | input | 5 | Register driving the Y bus |
| sel_z | input | 5 | Register written from the Z bus |
| reg_we | input | 1 | Register write enable |
| imm_en | input | 1 | Replace Y with the extended immediate |
| imm_val | input | 16 | Immediate constant |
| arith_en | input | 1 | Adder/subtractor drives Z |
| sub_mode | input | 1 | 0 add, 1 subtract |
| logic_en | input | 1 | Logic unit drives Z |
| logic_fn | input | 4 | Truth table of the logic unit |
| shift_en | input | 1 | Shifter drives Z |
| shift_kind | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 logical |
| shift_cnt | input | 6 | Signed count, positive right, negative left |
| load_en | input | 1 | Memory read data drives Z |
| store_en | input | 1 | Request a memory write |
| mem_rd | input | 1 | 1 read, 0 write |
| mem_sel | input | 1 | Memory select |
| x_bus | output | 32 | X operand |
| y_bus | output | 32 | Y operand |
| z_bus | output | 32 | Result bus |

## Verification
A register file that writes the wrong entry, or writes one edge late, shows up on `x_bus` in the cycle right after the write. Reading that register back in the next control word exposes it. A wrong shift stage or fill bit corrupts only certain counts and kinds, so the vectors cover every kind in both directions, including the saturated count. A memory fault stays hidden until the address is loaded again, so each store is followed by loads of the same word, of an aliased address, and after suppressed stores.

// File: rtl/dp_micro_pkg.sv
package dp_micro_pkg;

   typedef enum logic [1:0] {
      SHK_LOGIC = 2'd0,
      SHK_ARITH = 2'd1,
      SHK_ROT   = 2'd2,
      SHK_SPARE = 2'd3
   } shk_e;

   typedef struct packed {
      logic add_u;
      logic bool_u;
      logic shf_u;
      logic ld_u;
   } zsrc_t;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
   parameter int W     = 32,
   parameter int N     = 32,
   parameter int SW    = $clog2(N),
   parameter int PORTS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PORTS-1:0][SW-1:0] rsel,
   output logic [PORTS-1:0][W-1:0]  rdata,
   input  logic                     we,
   input  logic [SW-1:0]            wsel,
   input  logic [W-1:0]             wdata
);

   logic [W-1:0] regs_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[wsel] <= wdata;
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rport
      assign rdata[p] = regs_q[rsel[p]];
   end

endmodule

// File: rtl/dp_calc.sv
module dp_calc #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   input  logic [3:0]   table_fn,
   output logic [W-1:0] sum,
   output logic [W-1:0] bool_res
);

   logic [W-1:0] y_eff;

   assign y_eff = sub ? ~y : y;
   assign sum   = x + y_eff + W'(sub);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bool_res[i] = table_fn[{y[i], x[i]}];
   end

endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
   import dp_micro_pkg::*;
#(
   parameter int W  = 32,
   parameter int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] cnt,
   input  shk_e          kind,
   output logic [W-1:0]  dout
);

   localparam int SH = CW - 1;

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   logic          go_left;
   logic [CW-1:0] mag;
   logic [SH-1:0] amt;
   logic          rot;
   logic          fill;
   logic [SH:0][W-1:0] stg;

   assign go_left = cnt[CW-1];
   assign mag     = go_left ? (~cnt + CW'(1)) : cnt;
   assign amt     = mag[CW-1] ? '1 : mag[SH-1:0];
   assign rot     = (kind == SHK_ROT);
   assign fill    = (kind == SHK_ARITH) && !go_left && din[W-1];

   assign stg[0]  = go_left ? flip(din) : din;

   for (genvar s = 0; s < SH; s++) begin : g_stage
      localparam int D = 1 << s;
      assign stg[s+1] = !amt[s] ? stg[s] :
                        rot     ? {stg[s][D-1:0], stg[s][W-1:D]} :
                                  {{D{fill}}, stg[s][W-1:D]};
   end

   assign dout = go_left ? flip(stg[SH]) : stg[SH];

endmodule

// File: rtl/dp_dmem.sv
module dp_dmem #(
   parameter int W     = 32,
   parameter int WORDS = 256,
   parameter int AW    = $clog2(WORDS)
) (
   input  logic         clk,
   input  logic         wr,
   input  logic [W-1:0] addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata
);

   logic [W-1:0] mem_q [WORDS];
   logic [AW-1:0] idx;

   assign idx = addr[AW-1:0];

   if (AW < W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[W-1:AW];
   end

   always_ff @(posedge clk) begin
      if (wr) mem_q[idx] <= wdata;
   end

   assign rdata = mem_q[idx];

endmodule

// File: rtl/dp_micro_core.sv
module dp_micro_core
   import dp_micro_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREG      = 32,
   parameter int IMM_W     = 16,
   parameter int MEM_WORDS = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NREG)-1:0]    sel_x,
   input  logic [$clog2(NREG)-1:0]    sel_y,
   input  logic [$clog2(NREG)-1:0]    sel_z,
   input  logic                       reg_we,
   input  logic                       imm_en,
   input  logic [IMM_W-1:0]           imm_val,
   input  logic                       arith_en,
   input  logic                       sub_mode,
   input  logic                       logic_en,
   input  logic [3:0]                 logic_fn,
   input  logic                       shift_en,
   input  logic [1:0]                 shift_kind,
   input  logic [$clog2(DATA_W):0]    shift_cnt,
   input  logic                       load_en,
   input  logic                       store_en,
   input  logic                       mem_rd,
   input  logic                       mem_sel,
   output logic [DATA_W-1:0]          x_bus,
   output logic [DATA_W-1:0]          y_bus,
   output logic [DATA_W-1:0]          z_bus
);

   localparam int SEL_W = $clog2(NREG);
   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam int MA_W  = $clog2(MEM_WORDS);

   if (DATA_W < 8 || (1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (NREG < 2 || (1 << SEL_W) != NREG) begin : g_bad_n
      $error("NREG must be a power of two of at least 2");
   end
   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
      $error("IMM_W must lie in 1..DATA_W");
   end
   if ((1 << MA_W) != MEM_WORDS || MA_W > DATA_W) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two addressable by X");
   end

   logic [1:0][SEL_W-1:0]  rsel;
   logic [1:0][DATA_W-1:0] rdat;
   logic [DATA_W-1:0]      imm_ext;
   logic [DATA_W-1:0]      sum, bool_res, shf_res, mem_rdata;
   zsrc_t                  src;
   logic                   mem_wr;

   assign rsel[0] = sel_x;
   assign rsel[1] = sel_y;

   dp_regfile #(.W(DATA_W), .N(NREG), .SW(SEL_W), .PORTS(2)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .rsel  (rsel),
      .rdata (rdat),
      .we    (reg_we),
      .wsel  (sel_z),
      .wdata (z_bus)
   );

   assign imm_ext = DATA_W'($signed(imm_val));
   assign x_bus   = rdat[0];
   assign y_bus   = imm_en ? imm_ext : rdat[1];

   dp_calc #(.W(DATA_W)) u_calc (
      .x        (x_bus),
      .y        (y_bus),
      .sub      (sub_mode),
      .table_fn (logic_fn),
      .sum      (sum),
      .bool_res (bool_res)
   );

   dp_shifter #(.W(DATA_W), .CW(CNT_W)) u_shf (
      .din  (x_bus),
      .cnt  (shift_cnt),
      .kind (shk_e'(shift_kind)),
      .dout (shf_res)
   );

   assign mem_wr = store_en && mem_sel && !mem_rd;

   dp_dmem #(.W(DATA_W), .WORDS(MEM_WORDS), .AW(MA_W)) u_mem (
      .clk   (clk),
      .wr    (mem_wr),
      .addr  (x_bus),
      .wdata (y_bus),
      .rdata (mem_rdata)
   );

   assign src.add_u  = arith_en;
   assign src.bool_u = logic_en;
   assign src.shf_u  = shift_en;
   assign src.ld_u   = load_en && mem_sel && mem_rd;

   assign z_bus = ({DATA_W{src.add_u}}  & sum)
                | ({DATA_W{src.bool_u}} & bool_res)
                | ({DATA_W{src.shf_u}}  & shf_res)
                | ({DATA_W{src.ld_u}}   & mem_rdata);

endmodule

// File: rtl/dp_micro_core_chk.sv
module dp_micro_core_chk #(
   parameter int DATA_W    = 32,
   parameter int NREG      = 32,
   parameter int IMM_W     = 16,
   parameter int MEM_WORDS = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NREG)-1:0]    sel_x,
   input  logic [$clog2(NREG)-1:0]    sel_y,
   input  logic [$clog2(NREG)-1:0]    sel_z,
   input  logic                       reg_we,
   input  logic                       imm_en,
   input  logic [IMM_W-1:0]           imm_val,
   input  logic                       arith_en,
   input  logic                       sub_mode,
   input  logic                       logic_en,
   input  logic [3:0]                 logic_fn,
   input  logic                       shift_en,
   input  logic [1:0]                 shift_kind,
   input  logic [$clog2(DATA_W):0]    shift_cnt,
   input  logic                       load_en,
   input  logic                       store_en,
   input  logic                       mem_rd,
   input  logic                       mem_sel,
   input  logic [DATA_W-1:0]          x_bus,
   input  logic [DATA_W-1:0]          y_bus,
   input  logic [DATA_W-1:0]          z_bus
);

   logic live_q;
   logic none_on;
   logic only_add;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign none_on  = !arith_en && !logic_en && !shift_en && !load_en;
   assign only_add = arith_en && !logic_en && !shift_en && !load_en;

   // R10: producers on Z are mutually exclusive
   p_one_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({arith_en, logic_en, shift_en, load_en}) <= 1);

   // R10: idle Z bus
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      none_on |-> z_bus == '0);

   // R2: written value is visible on X in the next cycle
   p_writeback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(reg_we) && sel_x == $past(sel_z)) |-> x_bus == $past(z_bus));

   // R3: immediate replaces Y
   p_imm_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
      imm_en |-> y_bus == DATA_W'($signed(imm_val)));

   // R4: subtraction inverts addition
   p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (only_add && sub_mode) |-> (z_bus + y_bus) == x_bus);

   // R4: addition inverts subtraction
   p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (only_add && !sub_mode) |-> (z_bus - y_bus) == x_bus);

   // R7: zero count is a pass-through
   p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !arith_en && !logic_en && !load_en && shift_cnt == '0) |-> z_bus == x_bus);

endmodule

bind dp_micro_core dp_micro_core_chk #(
   .DATA_W    (DATA_W),
   .NREG      (NREG),
   .IMM_W     (IMM_W),
   .MEM_WORDS (MEM_WORDS)
) u_chk (.*);

// File: tb/dp_micro_core_tb.sv
module dp_micro_core_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  sel_x, sel_y, sel_z;
   logic        reg_we, imm_en;
   logic [15:0] imm_val;
   logic        arith_en, sub_mode, logic_en;
   logic [3:0]  logic_fn;
   logic        shift_en;
   logic [1:0]  shift_kind;
   logic [5:0]  shift_cnt;
   logic        load_en, store_en, mem_rd, mem_sel;
   logic [31:0] x_bus, y_bus, z_bus;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] mreg [32];

   always #2 clk = ~clk;

   dp_micro_core u_dut (.*);

   typedef struct packed {
      logic [1:0]  unit;   // 0 arith, 1 logic, 2 shift
      logic [4:0]  sx;
      logic [4:0]  sy;
      logic        ie;
      logic [15:0] imm;
      logic [3:0]  ctl;
      logic [5:0]  cnt;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 5'd1, 5'd2, 1'b0, 16'h0000, 4'h0, 6'h00, 4'd4},  // R4 add
      '{2'd0, 5'd3, 5'd4, 1'b0, 16'h0000, 4'h1, 6'h00, 4'd4},  // R4 sub
      '{2'd0, 5'd3, 5'd0, 1'b1, 16'h0007, 4'h1, 6'h00, 4'd3},  // R3 positive imm
      '{2'd0, 5'd2, 5'd0, 1'b1, 16'h8001, 4'h0, 6'h00, 4'd3},  // R3 negative imm
      '{2'd1, 5'd1, 5'd2, 1'b0, 16'h0000, 4'h8, 6'h00, 4'd5},  // R5 and
      '{2'd1, 5'd1, 5'd2, 1'b0, 16'h0000, 4'h6, 6'h00, 4'd5},  // R5 xor
      '{2'd1, 5'd1, 5'd2, 1'b0, 16'h0000, 4'h1, 6'h00, 4'd5},  // R5 nor
      '{2'd1, 5'd1, 5'd4, 1'b0, 16'h0000, 4'hA, 6'h00, 4'd5},  // R5 pass x
      '{2'd1, 5'd1, 5'd0, 1'b1, 16'hF0F0, 4'h4, 6'h00, 4'd5},  // R5 y and not x
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h0, 6'h04, 4'd6},  // R6 logical right
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h1, 6'h04, 4'd6},  // R6 arith right
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h2, 6'h08, 4'd6},  // R6 rotate right
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h3, 6'h04, 4'd6},  // R6 kind 3
      '{2'd2, 5'd4, 5'd0, 1'b0, 16'h0000, 4'h1, 6'h1F, 4'd6},  // R6 arith by 31
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h0, 6'h3C, 4'd7},  // R7 logical left 4
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h1, 6'h3C, 4'd7},  // R7 arith left 4
      '{2'd2, 5'd1, 5'd0, 1'b0, 16'h0000, 4'h2, 6'h38, 4'd7},  // R7 rotate left 8
      '{2'd2, 5'd1, 5'd0, 1'b0, 16'h0000, 4'h2, 6'h00, 4'd7},  // R7 zero count
      '{2'd2, 5'd1, 5'd0, 1'b0, 16'h0000, 4'h0, 6'h20, 4'd7},  // R7 count -32
      '{2'd2, 5'd2, 5'd0, 1'b0, 16'h0000, 4'h2, 6'h20, 4'd7}   // R7 rotate -32
   };

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] model(input vec_t v, input logic [31:0] xv, input logic [31:0] yv);
      int c;
      int n;
      case (v.unit)
         2'd0: return v.ctl[0] ? xv - yv : xv + yv;
         2'd1: return (v.ctl[0] ? (~xv & ~yv) : 32'h0) | (v.ctl[1] ? (xv & ~yv) : 32'h0)
                    | (v.ctl[2] ? (~xv & yv) : 32'h0) | (v.ctl[3] ? (xv & yv) : 32'h0);
         2'd2: begin
            c = $signed(v.cnt);
            n = (c < 0) ? -c : c;
            if (n > 31) n = 31;
            if (c >= 0) begin
               if (v.ctl[1:0] == 2'd1) return 32'($signed(xv) >>> n);
               if (v.ctl[1:0] == 2'd2) return (xv >> n) | (xv << (32 - n));
               return xv >> n;
            end
            if (v.ctl[1:0] == 2'd2) return (xv << n) | (xv >> (32 - n));
            return xv << n;
         end
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      sel_x = '0; sel_y = '0; sel_z = '0; reg_we = 0; imm_en = 0; imm_val = '0;
      arith_en = 0; sub_mode = 0; logic_en = 0; logic_fn = '0; shift_en = 0;
      shift_kind = '0; shift_cnt = '0; load_en = 0; store_en = 0; mem_rd = 0; mem_sel = 0;
   endtask

   task automatic cycle_end();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic put_imm(input int r, input logic [15:0] v);
      idle(); sel_x = 5'd0; imm_en = 1; imm_val = v; arith_en = 1; sel_z = 5'(r); reg_we = 1;
      cycle_end();
      mreg[r] = mreg[0] + sext(v);
   endtask

   task automatic shl16(input int r);
      idle(); sel_x = 5'(r); shift_en = 1; shift_cnt = 6'h30; sel_z = 5'(r); reg_we = 1;
      cycle_end();
      mreg[r] = mreg[r] << 16;
   endtask

   task automatic or_imm(input int r, input logic [15:0] v);
      idle(); sel_x = 5'(r); imm_en = 1; imm_val = v; logic_en = 1; logic_fn = 4'hE;
      sel_z = 5'(r); reg_we = 1;
      cycle_end();
      mreg[r] = mreg[r] | sext(v);
   endtask

   task automatic mem_load(input int ra, input logic [31:0] exp, input string req);
      idle(); sel_x = 5'(ra); load_en = 1; mem_sel = 1; mem_rd = 1;
      #1 check(z_bus == exp, req, z_bus, exp);
      cycle_end();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %h expected %h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mreg[i] = '0;
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      // R1: registers read zero during reset
      for (int r = 0; r < 32; r += 9) begin
         sel_x = 5'(r); sel_y = 5'(31 - r);
         #1 check(x_bus == 0 && y_bus == 0, "R1", x_bus | y_bus, 32'h0);
         @(negedge clk);
      end
      rst_n = 1;
      idle();
      @(negedge clk);
      sel_x = 5'd17;
      #1 check(x_bus == 0, "R1", x_bus, 32'h0);
      // R10: no producer gives zero
      check(z_bus == 0, "R10", z_bus, 32'h0);
      @(negedge clk);
      idle();

      // operand setup
      put_imm(1, 16'h1234); shl16(1); or_imm(1, 16'h5678);
      put_imm(2, 16'h8000); shl16(2); or_imm(2, 16'h0F0F);
      put_imm(3, 16'h0005);
      put_imm(4, 16'hFFFD);

      // R2: both read ports show the built values
      sel_x = 5'd1; sel_y = 5'd2;
      #1 check(x_bus == mreg[1], "R2", x_bus, mreg[1]);
      check(y_bus == mreg[2], "R2", y_bus, mreg[2]);
      @(negedge clk);

      // vector table
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         logic [31:0] xv, yv, e;
         v = VECS[k];
         idle();
         sel_x = v.sx; sel_y = v.sy; imm_en = v.ie; imm_val = v.imm;
         arith_en = (v.unit == 2'd0); sub_mode = v.ctl[0];
         logic_en = (v.unit == 2'd1); logic_fn = v.ctl;
         shift_en = (v.unit == 2'd2); shift_kind = v.ctl[1:0]; shift_cnt = v.cnt;
         xv = mreg[v.sx];
         yv = v.ie ? sext(v.imm) : mreg[v.sy];
         e  = model(v, xv, yv);
         #1 check(z_bus == e, $sformatf("R%0d vector %0d", v.req, k), z_bus, e);
         if (v.ie) check(y_bus == sext(v.imm), "R3", y_bus, sext(v.imm));
         @(negedge clk);
      end
      idle();

      // R2: same-cycle read returns the old value
      idle(); sel_x = 5'd6; imm_en = 1; imm_val = 16'h0042; arith_en = 1; sel_z = 5'd6; reg_we = 1;
      #1 check(x_bus == 32'h0, "R2", x_bus, 32'h0);
      check(z_bus == 32'h42, "R2", z_bus, 32'h42);
      cycle_end();
      sel_x = 5'd6; imm_en = 1; imm_val = 16'h0042; arith_en = 1; sel_z = 5'd6; reg_we = 1;
      #1 check(x_bus == 32'h42, "R2", x_bus, 32'h42);
      check(z_bus == 32'h84, "R2", z_bus, 32'h84);
      cycle_end();
      mreg[6] = 32'h84;
      sel_x = 5'd6;
      #1 check(x_bus == 32'h84, "R2", x_bus, 32'h84);
      @(negedge clk);

      // R8: store r1 at word 5, load it back
      idle(); sel_x = 5'd3; sel_y = 5'd1; store_en = 1; mem_sel = 1; mem_rd = 0;
      cycle_end();
      mem_load(3, mreg[1], "R8");
      // R9: load result written to a register
      idle(); sel_x = 5'd3; load_en = 1; mem_sel = 1; mem_rd = 1; sel_z = 5'd7; reg_we = 1;
      cycle_end();
      mreg[7] = mreg[1];
      sel_x = 5'd7;
      #1 check(x_bus == mreg[1], "R9", x_bus, mreg[1]);
      @(negedge clk);
      // R8: upper address bits ignored
      put_imm(8, 16'h0105);
      mem_load(8, mreg[1], "R8");
      // R9: load without select yields zero
      idle(); sel_x = 5'd3; load_en = 1; mem_sel = 0; mem_rd = 1;
      #1 check(z_bus == 32'h0, "R9", z_bus, 32'h0);
      cycle_end();
      // R11: store with read control set has no effect
      idle(); sel_x = 5'd3; sel_y = 5'd2; store_en = 1; mem_sel = 1; mem_rd = 1;
      cycle_end();
      mem_load(3, mreg[1], "R11");
      // R11: store without select has no effect
      idle(); sel_x = 5'd3; sel_y = 5'd2; store_en = 1; mem_sel = 0; mem_rd = 0;
      cycle_end();
      mem_load(3, mreg[1], "R11");

      // R10: write with no producer stores zero
      put_imm(9, 16'h7777);
      idle(); sel_z = 5'd9; reg_we = 1;
      cycle_end();
      mreg[9] = '0;
      sel_x = 5'd9;
      #1 check(x_bus == 32'h0, "R10", x_bus, 32'h0);
      @(negedge clk);

      // R2: register 0 is writable
      put_imm(0, 16'h0077);
      sel_x = 5'd0;
      #1 check(x_bus == 32'h77, "R2", x_bus, 32'h77);
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule